// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits between a host and a byte-wide parallel flash device. The host hands it one request at a time over a valid/ready channel: read one byte, program one byte, erase one sector, erase the whole array, or run a recovery write. The block turns each request into the flash's bus-cycle sequence. A read is a single timed strobe. A program is a string of four timed write strobes. Either erase is a string of six. Recovery is one write. Every strobe phase is held for a count of system clocks, and those counts come from parameters.

After the last write of a program or an erase, the block does not poll the device. It counts down the worst-case duration of that operation and then raises a one-cycle done pulse. For a read, the captured byte is presented with that pulse. The request channel exerts back-pressure: `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. Anything offered while `req_ready` is low is neither taken nor remembered.

The data bus is split into an output value, an output-enable and an input value, so that the pad ring can build the tri-state buffer.

Top module: `flash_host_ctrl`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_oe_n` and `fl_we_n` are 1, `fl_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: A request with `req_op`=1 (program) writes, in this order: AAh at 05555h, 55h at 02AAAh, A0h at 05555h, then `req_wdata` at `req_addr`. A write is recorded on each rising edge of `fl_we_n`.
- R3: A request with `req_op`=2 (sector erase) writes, in this order: AAh at 05555h, 55h at 02AAAh, 80h at 05555h, AAh at 05555h, 55h at 02AAAh, then 30h at `req_addr`.
- R4: A request with `req_op`=3 (chip erase) writes the same first five as R3. The sixth write is 10h at 05555h.
- R5: A request with `req_op`=4 (recovery) writes exactly one cycle, FFh at 05555h.
- R6: Each `fl_we_n` low pulse lasts exactly WP_CYC clocks. Between two pulses of one request, `fl_we_n` stays high for max(WPH_CYC, WC_CYC−WP_CYC−1)+1 clocks, so each full write cycle lasts at least WC_CYC clocks.
- R7: During every write, `fl_dq_oe` is already 1 on the clock before `fl_we_n` falls. `fl_addr`, `fl_dq_out` and `fl_dq_oe`=1 do not change while `fl_we_n` is low.
- R8: A request with `req_op`=0 (read) holds `fl_ce_n`=0, `fl_oe_n`=0 and `fl_we_n`=1 for exactly ACC_CYC clocks. The bus is sampled at the end of that window, and the sampled byte appears on `rd_data` while `done` is high.
- R9: `done` rises exactly W+N clocks after the final rising edge of `fl_we_n`. Here W=max(WPH_CYC, WC_CYC−WP_CYC−1) and N is PROG_WAIT, SECT_WAIT or CHIP_WAIT for a program, sector erase or chip erase, and 0 for recovery.
- R10: `fl_dq_oe` is never 1 while `fl_oe_n` is 0.
- R11: `req_ready` is 0 from acceptance until after `done`. Requests offered meanwhile cause no flash write and no extra `done`. Each accepted request yields exactly one one-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_op | input | 3 | 0 read, 1 program, 2 sector erase, 3 chip erase, 4 recovery |
| req_addr | input | ADDR_W | Byte address for read/program, any address in the sector for sector erase |
| req_wdata | input | DATA_W | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | DATA_W | Value driven onto the flash data bus |
| fl_dq_oe | output | 1 | Host drives the data bus when 1 |
| fl_dq_in | input | DATA_W | Value read from the flash data bus |

## Verification
The two functions that can land on the same clock are the handshake and the completion pulse. `done` and a fresh request offered in anticipation of it can both be present on one edge. Other collisions involve the bus release and the start of a read. The bench holds `req_valid` high through a whole program operation, including its done cycle. It then checks two things: no write beyond the four expected ones reached the flash, and only one `done` appeared. A back-to-back read after a write sequence checks that `fl_dq_oe` drops no later than the edge on which `fl_oe_n` falls.

// File: rtl/flash_host_pkg.sv
package flash_host_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_PROG  = 3'd1,
    OP_SECT  = 3'd2,
    OP_CHIP  = 3'd3,
    OP_RECOV = 3'd4
  } fl_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WHIGH,
    ST_READ,
    ST_WAIT,
    ST_DONE
  } fl_state_e;

  localparam int unsigned UNLOCK_ADDR_A = 32'h5555;
  localparam int unsigned UNLOCK_ADDR_B = 32'h2AAA;

endpackage

// File: rtl/flash_cmd_table.sv
module flash_cmd_table
  import flash_host_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  fl_op_e              op,
  input  logic [2:0]          step,
  input  logic [ADDR_W-1:0]   tgt_addr,
  input  logic [DATA_W-1:0]   tgt_data,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [2:0]          last_step
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLOCK_ADDR_A);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLOCK_ADDR_B);

  always_comb begin
    unique case (op)
      OP_PROG:          last_step = 3'd3;
      OP_SECT, OP_CHIP: last_step = 3'd5;
      default:          last_step = 3'd0;
    endcase
  end

  always_comb begin
    wr_addr = A_HI;
    wr_data = DATA_W'(8'hAA);
    if (op == OP_RECOV) begin
      wr_data = DATA_W'(8'hFF);
    end else begin
      unique case (step)
        3'd1, 3'd4: begin
          wr_addr = A_LO;
          wr_data = DATA_W'(8'h55);
        end
        3'd2: wr_data = (op == OP_PROG) ? DATA_W'(8'hA0) : DATA_W'(8'h80);
        3'd3: begin
          if (op == OP_PROG) begin
            wr_addr = tgt_addr;
            wr_data = tgt_data;
          end
        end
        3'd5: begin
          if (op == OP_SECT) begin
            wr_addr = tgt_addr;
            wr_data = DATA_W'(8'h30);
          end else begin
            wr_data = DATA_W'(8'h10);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flash_dly_tmr.sv
module flash_dly_tmr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_host_ctrl.sv
module flash_host_ctrl
  import flash_host_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int WP_CYC    = 5,
  parameter int WPH_CYC   = 3,
  parameter int WC_CYC    = 9,
  parameter int ACC_CYC   = 9,
  parameter int PROG_WAIT = 3000,
  parameter int SECT_WAIT = 1000000,
  parameter int CHIP_WAIT = 300000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [DATA_W-1:0] fl_dq_in
);
  localparam int HI_FILL = WC_CYC - WP_CYC - 1;
  localparam int WPH_EFF = (HI_FILL > WPH_CYC) ? HI_FILL : WPH_CYC;
  localparam int MAX_W1  = (SECT_WAIT > PROG_WAIT) ? SECT_WAIT : PROG_WAIT;
  localparam int MAX_W   = (CHIP_WAIT > MAX_W1) ? CHIP_WAIT : MAX_W1;
  localparam int CNT_W   = $clog2(MAX_W + 1) + 1;

  fl_state_e         st_q, st_nxt;
  fl_op_e            op_q, tbl_op;
  logic [2:0]        step_q, tbl_step, last_step;
  logic [ADDR_W-1:0] tgt_q, tbl_tgt, tbl_addr;
  logic [DATA_W-1:0] dat_q, tbl_dat, tbl_wdata;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic [CNT_W-1:0]  post_wait;
  logic              accept;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // the command table sees the incoming request while idle, the held one otherwise
  assign tbl_op   = (st_q == ST_IDLE) ? fl_op_e'(req_op) : op_q;
  assign tbl_tgt  = (st_q == ST_IDLE) ? req_addr : tgt_q;
  assign tbl_dat  = (st_q == ST_IDLE) ? req_wdata : dat_q;
  assign tbl_step = (st_q == ST_IDLE) ? 3'd0 :
                    (st_q == ST_WHIGH) ? step_q + 3'd1 : step_q;

  flash_cmd_table #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .op        (tbl_op),
    .step      (tbl_step),
    .tgt_addr  (tbl_tgt),
    .tgt_data  (tbl_dat),
    .wr_addr   (tbl_addr),
    .wr_data   (tbl_wdata),
    .last_step (last_step)
  );

  flash_dly_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    unique case (op_q)
      OP_PROG: post_wait = CNT_W'(PROG_WAIT);
      OP_SECT: post_wait = CNT_W'(SECT_WAIT);
      OP_CHIP: post_wait = CNT_W'(CHIP_WAIT);
      default: post_wait = '0;
    endcase
  end

  always_comb begin
    st_nxt   = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        if (fl_op_e'(req_op) == OP_READ) begin
          st_nxt   = ST_READ;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(ACC_CYC - 1);
        end else begin
          st_nxt = ST_WSET;
        end
      end
      ST_WSET: begin
        st_nxt   = ST_WLOW;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WLOW: if (tmr_exp) begin
        st_nxt   = ST_WHIGH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WPH_EFF - 1);
      end
      ST_WHIGH: if (tmr_exp) begin
        if (step_q != last_step) begin
          st_nxt = ST_WSET;
        end else if (post_wait == '0) begin
          st_nxt = ST_DONE;
        end else begin
          st_nxt   = ST_WAIT;
          tmr_load = 1'b1;
          tmr_val  = post_wait - 1'b1;
        end
      end
      ST_READ: if (tmr_exp) st_nxt = ST_DONE;
      ST_WAIT: if (tmr_exp) st_nxt = ST_DONE;
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_READ;
      step_q    <= '0;
      tgt_q     <= '0;
      dat_q     <= '0;
      rd_data   <= '0;
      done      <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
      fl_dq_oe  <= 1'b0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
    end else begin
      st_q <= st_nxt;
      if (accept) begin
        op_q   <= fl_op_e'(req_op);
        tgt_q  <= req_addr;
        dat_q  <= req_wdata;
        step_q <= '0;
      end else if (st_q == ST_WHIGH && st_nxt == ST_WSET) begin
        step_q <= step_q + 3'd1;
      end
      if (st_q == ST_READ && tmr_exp) rd_data <= fl_dq_in;
      // pins are registered from the next state so they never glitch
      done     <= (st_nxt == ST_DONE);
      fl_ce_n  <= !(st_nxt inside {ST_WSET, ST_WLOW, ST_WHIGH, ST_READ});
      fl_oe_n  <= (st_nxt != ST_READ);
      fl_we_n  <= (st_nxt != ST_WLOW);
      fl_dq_oe <= (st_nxt inside {ST_WSET, ST_WLOW, ST_WHIGH});
      if (st_nxt == ST_READ) begin
        fl_addr <= tbl_tgt;
      end else if (st_nxt == ST_WSET) begin
        fl_addr   <= tbl_addr;
        fl_dq_out <= tbl_wdata;
      end
    end
  end
endmodule

// File: rtl/flash_host_chk.sv
module flash_host_chk #(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 8,
  parameter int WP_CYC    = 5,
  parameter int WPH_CYC   = 3,
  parameter int WC_CYC    = 9,
  parameter int ACC_CYC   = 9,
  parameter int PROG_WAIT = 3000,
  parameter int SECT_WAIT = 1000000,
  parameter int CHIP_WAIT = 300000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic              fl_ce_n,
  input logic              fl_oe_n,
  input logic              fl_we_n,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_dq_out,
  input logic              fl_dq_oe,
  input logic [DATA_W-1:0] fl_dq_in
);
  logic [15:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_run <= '0;
    else if (!fl_we_n) lo_run <= lo_run + 16'd1;
    else               lo_run <= '0;
  end

  assert_no_bus_fight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);

  assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (lo_run == 16'(WP_CYC)));

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

  assert_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $past(fl_dq_oe));

  assert_read_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (fl_we_n && !fl_ce_n));

  assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_not_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!req_ready && $past(!done)));
endmodule

bind flash_host_ctrl flash_host_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_CYC(WP_CYC), .WPH_CYC(WPH_CYC),
  .WC_CYC(WC_CYC), .ACC_CYC(ACC_CYC), .PROG_WAIT(PROG_WAIT),
  .SECT_WAIT(SECT_WAIT), .CHIP_WAIT(CHIP_WAIT)
) u_chk (.*);

// File: tb/flash_host_ctrl_test.sv
module flash_host_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int P_WP = 5;
  localparam int P_WPH = 3;
  localparam int P_WC = 12;
  localparam int P_ACC = 9;
  localparam int P_PROG = 40;
  localparam int P_SECT = 70;
  localparam int P_CHIP = 100;
  // expected high fill between pulses (R6/R9), from the requirement formula
  localparam int EXP_HI = (P_WC - P_WP - 1 > P_WPH) ? P_WC - P_WP - 1 : P_WPH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic done;
  logic [DW-1:0] rd_data;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out, fl_dq_in;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_host_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .WP_CYC(P_WP), .WPH_CYC(P_WPH), .WC_CYC(P_WC),
    .ACC_CYC(P_ACC), .PROG_WAIT(P_PROG), .SECT_WAIT(P_SECT), .CHIP_WAIT(P_CHIP)
  ) uut (.*);

  // flash read model: valid data only after OE has been low long enough
  int olow = 0;
  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {2'b00, a[17:12]} ^ 8'h3C;
  endfunction
  always @(posedge clk) olow <= fl_oe_n ? 0 : olow + 1;
  assign fl_dq_in = (!fl_oe_n && olow >= P_ACC - 1) ? pat(fl_addr) : 8'hEE;

  // bus monitor, sampled on the falling edge
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];
  int log_n = 0, done_n = 0, cyc = 0;
  int lo_cnt = 0, hi_cnt = 0, oe_cnt = 0, rise_cyc = 0, done_gap = 0;
  int v_lo = 0, v_hi = 0, v_hold = 0, v_setup = 0, v_bus = 0, v_rd = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1, prev_dqoe = 1'b0, in_seq = 1'b0;
  logic [AW-1:0] fa;
  logic [DW-1:0] fd;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!fl_oe_n && fl_dq_oe) v_bus <= v_bus + 1;
    if (prev_we && !fl_we_n) begin
      if (!prev_dqoe) v_setup <= v_setup + 1;
      if (in_seq && hi_cnt != EXP_HI + 1) v_hi <= v_hi + 1;
      fa = fl_addr; fd = fl_dq_out;
      lo_cnt <= 1;
    end else if (!fl_we_n) begin
      if (fl_addr != fa || fl_dq_out != fd || !fl_dq_oe) v_hold <= v_hold + 1;
      lo_cnt <= lo_cnt + 1;
    end else if (!prev_we && fl_we_n) begin
      if (lo_cnt != P_WP) v_lo <= v_lo + 1;
      log_a[log_n % 64] <= fa;
      log_d[log_n % 64] <= fd;
      log_n <= log_n + 1;
      rise_cyc <= cyc;
      in_seq <= 1'b1;
      hi_cnt <= 1;
    end else begin
      hi_cnt <= hi_cnt + 1;
    end
    if (!fl_oe_n) oe_cnt <= oe_cnt + 1;
    else begin
      if (!prev_oe && oe_cnt != P_ACC) v_rd <= v_rd + 1;
      oe_cnt <= 0;
    end
    if (done) begin
      done_n <= done_n + 1;
      done_gap <= cyc - rise_cyc;
      in_seq <= 1'b0;
    end
    prev_we = fl_we_n;
    prev_oe = fl_oe_n;
    prev_dqoe = fl_dq_oe;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_seq(input string tag, input int base, input int n,
                           input logic [AW-1:0] ea [6], input logic [DW-1:0] ed [6]);
    chk(log_n - base == n, {tag, " write count"}, log_n - base, n);
    for (int i = 0; i < n; i++) begin
      chk(log_a[(base + i) % 64] == ea[i], {tag, " addr"}, int'(log_a[(base + i) % 64]), int'(ea[i]));
      chk(log_d[(base + i) % 64] == ed[i], {tag, " data"}, int'(log_d[(base + i) % 64]), int'(ed[i]));
    end
  endtask

  task automatic t_reset();
    chk(fl_ce_n && fl_oe_n && fl_we_n, "R1 strobes idle", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    chk(!fl_dq_oe && !done && req_ready, "R1 oe/done/ready", {fl_dq_oe, done, req_ready}, 1);
  endtask

  task automatic t_program(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int b = log_n, dn = done_n;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, a, 0, 0};
    logic [DW-1:0] ed [6] = '{8'hAA, 8'h55, 8'hA0, d, 0, 0};
    issue(3'd1, a, d);
    check_seq("R2 program", b, 4, ea, ed);
    chk(done_gap == EXP_HI + P_PROG, "R9 program wait", done_gap, EXP_HI + P_PROG);
    chk(done_n - dn == 1, "R11 one done", done_n - dn, 1);
  endtask

  task automatic t_sector(input logic [AW-1:0] a);
    int b = log_n;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, 18'h05555, 18'h02AAA, a};
    logic [DW-1:0] ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h30};
    issue(3'd2, a, 8'h00);
    check_seq("R3 sector erase", b, 6, ea, ed);
    chk(done_gap == EXP_HI + P_SECT, "R9 sector wait", done_gap, EXP_HI + P_SECT);
  endtask

  task automatic t_chip();
    int b = log_n;
    logic [AW-1:0] ea [6] = '{18'h05555, 18'h02AAA, 18'h05555, 18'h05555, 18'h02AAA, 18'h05555};
    logic [DW-1:0] ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
    issue(3'd3, 18'h3ABCD, 8'h77);
    check_seq("R4 chip erase", b, 6, ea, ed);
    chk(done_gap == EXP_HI + P_CHIP, "R9 chip wait", done_gap, EXP_HI + P_CHIP);
  endtask

  task automatic t_recover();
    int b = log_n;
    logic [AW-1:0] ea [6] = '{18'h05555, 0, 0, 0, 0, 0};
    logic [DW-1:0] ed [6] = '{8'hFF, 0, 0, 0, 0, 0};
    issue(3'd4, 18'h12345, 8'h00);
    check_seq("R5 recovery", b, 1, ea, ed);
    chk(done_gap == EXP_HI, "R9 recovery no wait", done_gap, EXP_HI);
  endtask

  task automatic t_read(input logic [AW-1:0] a);
    int b = log_n;
    issue(3'd0, a, 8'h00);
    chk(rd_data == pat(a), "R8 read data", rd_data, pat(a));
    chk(log_n == b, "R8 read writes nothing", log_n - b, 0);
  endtask

  task automatic t_busy();
    int b = log_n, dn = done_n, rdy_seen = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = 3'd1; req_addr = 18'h00042; req_wdata = 8'h5A;
    @(negedge clk);
    req_op = 3'd4;
    // keep offering through the done cycle; drop before the edge that returns to idle
    while (!done) begin
      if (req_ready) rdy_seen++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk(rdy_seen == 0, "R11 ready low while busy", rdy_seen, 0);
    chk(log_n - b == 4, "R11 no extra writes", log_n - b, 4);
    chk(done_n - dn == 1, "R11 single done", done_n - dn, 1);
  endtask

  task automatic t_timing();
    chk(v_lo == 0, "R6 WE low width", v_lo, 0);
    chk(v_hi == 0, "R6 WE high width", v_hi, 0);
    chk(v_setup == 0, "R7 data setup", v_setup, 0);
    chk(v_hold == 0, "R7 addr/data hold", v_hold, 0);
    chk(v_bus == 0, "R10 bus contention", v_bus, 0);
    chk(v_rd == 0, "R8 OE low window", v_rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program(18'h1F00F, 8'h96);
    t_read(18'h1F00F);
    t_program(18'h00001, 8'h00);
    t_sector(18'h2C400);
    t_chip();
    t_recover();
    t_read(18'h3FFFF);
    t_busy();
    t_read(18'h00000);
    t_timing();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule